// File: doc/BRIEF.md
# Bit-Serial Two's Complement Negator

This block negates a binary word one bit at a time. Bits enter least-significant first with a valid flag. For each valid bit, one negated bit leaves in the same cycle. The core holds a single carry flip-flop, which is preset to one at the start of every word. A half adder combines that carry with the inverted input bit. The result is that every bit up to and including the first one passes through unchanged, and every bit above it is inverted.

The top module wraps the core between two registers:
- A parallel-load shifter serialises a word, one bit per cycle in which `step` is high.
- A collector gathers the negated bits and flags completion once the configured number of bits has been processed.

The `step` input lets the feeding side pause between bits. There is no overflow indication: the most negative value maps to itself.

Top module: `serial_negate_top`

## Requirements
- R1: The word is processed least-significant bit first, one bit per cycle in which the shifter is busy and `step` is high. `neg_vld` is high in exactly those cycles, and `neg_bit` is valid in the same cycle.
- R2: The carry is one after reset and is forced to one for the first bit of every word. That first bit therefore leaves unchanged, whatever carry the previous word left behind.
- R3: Output bits equal input bits up to and including the first input one. Every later bit is inverted. Taken together, the serial output is (2^WIDTH - word) mod 2^WIDTH; for example, 001010 gives 110110.
- R4: In cycles with `step` low, `neg_vld` stays low and the carry keeps its value, so pauses between bits do not change the result.
- R5: A zero word negates to zero, with the carry staying one throughout. The most negative word (top bit one, the rest zero) negates to itself.
- R6: When `load_en` is high, the shifter captures `load_word`, clears `done` and restarts, even if a conversion is in progress. `load_en` has priority over `step`.
- R7: After WIDTH output bits, `done` goes high and `result` holds the negated word. Both hold until the next load.
- R8: After synchronous reset, `done` is 0, `result` is 0 and `neg_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Capture `load_word` and start a new word |
| load_word | input | WIDTH | Parallel word to negate |
| step | input | 1 | Advance one bit this cycle |
| neg_bit | output | 1 | Current negated bit |
| neg_vld | output | 1 | `neg_bit` is valid |
| result | output | WIDTH | Collected negated word |
| done | output | 1 | `result` is complete |

## Verification
The embedded assertions check the following on every cycle:
- the first bit of each word passes unchanged;
- a one on the input clears the carry;
- once the carry is clear, bits are inverted;
- idle cycles leave the carry untouched;
- valid bits appear only while the shifter is busy;
- `done` holds until a load.

Only the bench's scenarios can show the whole-word arithmetic results, the zero and most-negative cases, the forced carry after an aborted word, and correct results under sparse `step` patterns.

// File: rtl/sn_pkg.sv
package sn_pkg;

    typedef struct packed {
        logic carry;
    } core_st_t;

    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sn_carry_core.sv
module sn_carry_core (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic in_bit,
    input  logic in_vld,
    output logic out_bit,
    output logic out_vld
);
    import sn_pkg::*;

    core_st_t st_d, st_q;
    logic     cin;
    logic     inv;

    always_comb begin
        st_d    = st_q;
        cin     = start ? 1'b1 : st_q.carry;
        inv     = ~in_bit;
        out_bit = inv ^ cin;
        out_vld = in_vld;
        if (in_vld) begin
            st_d.carry = inv & cin;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.carry <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R2
    first_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && start) |-> (out_bit == in_bit));

    // R3
    carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_bit) |=> !st_q.carry);

    // R3
    invert_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !start && !st_q.carry) |-> (out_bit != in_bit));

    // R4
    carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(st_q.carry));

endmodule

// File: rtl/sn_shift_src.sv
module sn_shift_src #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_word,
    input  logic             step,
    output logic             s_bit,
    output logic             s_vld,
    output logic             s_start
);
    localparam int CW = sn_pkg::cnt_bits(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] sh;
        logic [CW-1:0]    cnt;
        logic             busy;
        logic             first;
    } src_st_t;

    src_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        s_bit   = st_q.sh[0];
        s_vld   = st_q.busy && step && !load_en;
        s_start = st_q.first && s_vld;
        if (load_en) begin
            st_d.sh    = load_word;
            st_d.cnt   = '0;
            st_d.busy  = 1'b1;
            st_d.first = 1'b1;
        end else if (s_vld) begin
            st_d.sh    = {1'b0, st_q.sh[WIDTH-1:1]};
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.first = 1'b0;
            if (st_q.cnt == CW'(WIDTH - 1)) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1
    vld_busy_chk: assert property (@(posedge clk) disable iff (rst)
        s_vld |-> (st_q.busy && st_q.cnt < CW'(WIDTH)));

    // R6
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (st_q.busy && st_q.first));

endmodule

// File: rtl/sn_collect.sv
module sn_collect #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_bit,
    input  logic             in_vld,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    localparam int CW = sn_pkg::cnt_bits(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] acc;
        logic [WIDTH-1:0] res;
        logic [CW-1:0]    cnt;
        logic             done;
    } col_st_t;

    col_st_t          st_d, st_q;
    logic [WIDTH-1:0] acc_n;

    always_comb begin
        st_d   = st_q;
        acc_n  = {in_bit, st_q.acc[WIDTH-1:1]};
        result = st_q.res;
        done   = st_q.done;
        if (clr) begin
            st_d.acc  = '0;
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (in_vld) begin
            st_d.acc = acc_n;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(WIDTH - 1)) begin
                st_d.res  = acc_n;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.done && !clr) |=> st_q.done);

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.done) |-> $past(in_vld));

endmodule

// File: rtl/serial_negate_top.sv
module serial_negate_top #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_word,
    input  logic             step,
    output logic             neg_bit,
    output logic             neg_vld,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    logic s_bit, s_vld, s_start;

    sn_shift_src #(.WIDTH(WIDTH)) u_src (
        .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word),
        .step(step), .s_bit(s_bit), .s_vld(s_vld), .s_start(s_start)
    );

    sn_carry_core u_core (
        .clk(clk), .rst(rst), .start(s_start), .in_bit(s_bit),
        .in_vld(s_vld), .out_bit(neg_bit), .out_vld(neg_vld)
    );

    sn_collect #(.WIDTH(WIDTH)) u_col (
        .clk(clk), .rst(rst), .clr(load_en), .in_bit(neg_bit),
        .in_vld(neg_vld), .result(result), .done(done)
    );

    // R1
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !step |-> !neg_vld);

endmodule

// File: tb/serial_negate_top_bench.sv
module serial_negate_top_bench;
    localparam int CLK_P = 10;
    localparam int W     = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         load_en;
    logic [W-1:0] load_word;
    logic         step;
    logic         neg_bit;
    logic         neg_vld;
    logic [W-1:0] result;
    logic         done;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    serial_negate_top #(.WIDTH(W)) u_serial_negate_top (
        .clk(clk), .rst(rst), .load_en(load_en), .load_word(load_word),
        .step(step), .neg_bit(neg_bit), .neg_vld(neg_vld),
        .result(result), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int negate(input int w);
        return ((1 << W) - w) % (1 << W);
    endfunction

    // Load a word, then step it out. A step happens in cycles where cyc % per == per-1.
    task automatic do_word(input int w, input int per, input string tag);
        int exp_v;
        int idx;
        int cyc;
        exp_v = negate(w);
        @(negedge clk);
        load_en   = 1'b1;
        load_word = W'(w);
        step      = 1'b1;
        #1;
        check(neg_vld == 1'b0, "R6 load has priority over step", int'(neg_vld), 0);
        @(negedge clk);
        load_en = 1'b0;
        #1;
        check(done == 1'b0, "R6 done cleared by load", int'(done), 0);
        idx = 0;
        cyc = 0;
        while (idx < W) begin
            step = ((cyc % per) == per - 1);
            #1;
            check(neg_vld == step, "R1/R4 neg_vld follows step", int'(neg_vld), int'(step));
            if (step) begin
                check(neg_bit == ((exp_v >> idx) & 1), {"R3 bit of ", tag},
                      int'(neg_bit), (exp_v >> idx) & 1);
                idx++;
            end
            @(negedge clk);
            cyc++;
        end
        step = 1'b0;
        #1;
        check(done == 1'b1, {"R7 done for ", tag}, int'(done), 1);
        check(int'(result) == exp_v, {"R7 result for ", tag}, int'(result), exp_v);
        check(neg_vld == 1'b0, "R1 no bits after word", int'(neg_vld), 0);
        @(negedge clk);
        #1;
        check(done == 1'b1 && int'(result) == exp_v, "R7 result held", int'(result), exp_v);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; load_en = 1'b0; load_word = '0; step = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R8
        check(done == 1'b0, "R8 done after reset", int'(done), 0);
        check(result == '0, "R8 result after reset", int'(result), 0);
        check(neg_vld == 1'b0, "R8 neg_vld after reset", int'(neg_vld), 0);

        do_word(6'b001010, 1, "R3 example 001010");
        do_word(6'b000000, 1, "R5 zero word");
        do_word(6'b100000, 1, "R5 most negative");
        do_word(6'b000001, 2, "R3 lsb one, R4 alternate step");
        do_word(6'b111111, 1, "R3 all ones");
        do_word(6'b010111, 4, "R4 sparse step");
        do_word(6'b101100, 3, "R3 mid one");

        // R2 / R6: abort a word after its first one, leaving the carry at 0, then restart
        @(negedge clk);
        load_en = 1'b1; load_word = 6'b000001; step = 1'b0;
        @(negedge clk);
        load_en = 1'b0; step = 1'b1;
        #1;
        check(neg_bit == 1'b1, "R2 first bit of aborted word", int'(neg_bit), 1);
        @(negedge clk);
        #1;
        check(neg_bit == 1'b1, "R3 inverted bit of aborted word", int'(neg_bit), 1);
        @(negedge clk);
        step = 1'b0;
        do_word(6'b000010, 1, "R2 restart forces carry");
        do_word(6'b000110, 2, "R2 word after carry cleared");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule